// File: doc/BRIEF.md
# Dual-Channel Gain Source Selector

This block sits in front of a two-channel digitally stepped amplifier. It holds one 6-bit attenuation code per channel and decides which of three sources may update that code: a direct parallel bus, a serial port engine, or an up/down stepping engine. A shared 2-bit mode input picks the source for both channels. Code 0 is the highest gain and code 63 the lowest, and each code step is 0.5 dB. The serial and stepping engines are separate blocks. Here they appear only as a code plus a one-cycle write strobe for each channel.

In parallel mode, each channel has a hold input. While hold is low, the channel's register reloads from its six parallel pins on every clock, which acts as a transparent latch. While hold is high, the register keeps its value. Two 6-pin groups are shared by all three interfaces. The block also fans the same pins out to the serial and stepping engines, and it parks those engine inputs in their idle state when their mode is not selected. A channel whose power-up input is low accepts no update, so its code survives power-down. Reset sets both channels to code 63.

Top module: `gainsel_top`

## Requirements
- R1: While reset (rstN low) is asserted, and in the first cycle after it, both gain codes read 63 (6'b111111, minimum gain).
- R2: With mode 2'b00 (parallel), a powered channel whose hold input is low shows its 6 parallel pins on its gain output one clock after they are sampled.
- R3: With mode 2'b00, a channel whose hold input is high keeps its gain code no matter how its parallel pins change.
- R4: With mode 2'b01 (serial), a powered channel loads its serial code in the clock where its serial write strobe is high, and its parallel pins have no effect.
- R5: With mode 2'b10 or 2'b11 (both up/down), a powered channel loads its stepper code in the clock where its stepper write strobe is high.
- R6: A write strobe from a source that the current mode does not select leaves the gain code unchanged, and so does a change of mode on its own.
- R7: While a channel's power-up input is low, its gain code does not change. After power-up returns high, the code is the value it held before.
- R8: The two channels are independent: the hold, strobe and power-up inputs of one channel never change the other channel's code.
- R9: In mode 2'b01, the serial engine inputs are routed from the shared pins. Channel A chip select (active low) comes from pinsA[3] and channel B chip select from pinsB[3]. Serial clock comes from pinsB[4] and serial data from pinsB[5]. Fast-attack A comes from pinsA[2] and fast-attack B from pinsB[2]. In any other mode, both chip selects read 1 and the other serial outputs read 0.
- R10: In mode 2'b10 or 2'b11, the stepper inputs are routed from the shared pins. Channel A step clock comes from pinsA[1] and step data from pinsA[0]. Channel B step clock comes from pinsB[1] and step data from pinsB[0]. The step-size select is {pinsB[3], pinsB[2]}. In any other mode, all of these read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Interface mode: 00 parallel, 01 serial, 1x up/down |
| pinsA | input | 6 | Shared pin group A (parallel code for channel A) |
| pinsB | input | 6 | Shared pin group B (parallel code for channel B) |
| holdA | input | 1 | Channel A parallel hold (1 = keep) |
| holdB | input | 1 | Channel B parallel hold (1 = keep) |
| pwrUpA | input | 1 | Channel A powered when 1 |
| pwrUpB | input | 1 | Channel B powered when 1 |
| serCodeA | input | 6 | Serial engine code for channel A |
| serWrA | input | 1 | Serial write strobe for channel A |
| serCodeB | input | 6 | Serial engine code for channel B |
| serWrB | input | 1 | Serial write strobe for channel B |
| stepCodeA | input | 6 | Stepper engine code for channel A |
| stepWrA | input | 1 | Stepper write strobe for channel A |
| stepCodeB | input | 6 | Stepper engine code for channel B |
| stepWrB | input | 1 | Stepper write strobe for channel B |
| serCsN | output | 2 | Serial chip selects, active low, bit 0 = A |
| serClk | output | 1 | Serial clock to engine |
| serDio | output | 1 | Serial data to engine |
| fastAtk | output | 2 | Fast-attack requests, bit 0 = A |
| stepClk | output | 2 | Step clocks, bit 0 = A |
| stepDat | output | 2 | Step direction data, bit 0 = A |
| stepSize | output | 2 | Step-size select |
| gainA | output | 6 | Channel A stored gain code |
| gainB | output | 6 | Channel B stored gain code |

## Verification
On every cycle, the assertions check the per-channel load rules. They confirm that a transparent channel takes its pins, a held or powered-down channel stays stable, a selected strobe loads its code, and the idle state of the routed engine pins is correct outside their mode. Some behaviour spans several cycles, and only the bench's scenarios can show it. This covers the value kept through a power-down and recovered afterwards, codes kept across a run of mode changes, strobes from an unselected source being ignored, and channel independence under mixed hold settings. The bench tracks these with a behavioural model that it compares on every clock.

// File: rtl/gainsel_pkg.sv
package gainsel_pkg;
  typedef enum logic [1:0] {
    MODE_PAR   = 2'b00,
    MODE_SER   = 2'b01,
    MODE_STEP0 = 2'b10,
    MODE_STEP1 = 2'b11
  } modeE;

  typedef struct packed {
    logic loadPar;
    logic loadSer;
    logic loadStep;
  } chStrobeT;

  // Shared-pin bit positions decoded by the neighbouring engines
  localparam int PIN_CS      = 3;
  localparam int PIN_FA      = 2;
  localparam int PIN_SCLK    = 4;
  localparam int PIN_SDIO    = 5;
  localparam int PIN_STEPCLK = 1;
  localparam int PIN_STEPDAT = 0;
  localparam int PIN_GSHI    = 3;
  localparam int PIN_GSLO    = 2;
endpackage

// File: rtl/gainsel_ctrl.sv
module gainsel_ctrl
  import gainsel_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CODE_W = 6
) (
  input  logic [1:0]              modeSel,
  input  logic [NCH-1:0]          hold,
  input  logic [NCH-1:0]          pwrUp,
  input  logic [NCH-1:0]          serWr,
  input  logic [NCH-1:0]          stepWr,
  input  logic [CODE_W-1:0]       pinsA,
  input  logic [CODE_W-1:0]       pinsB,
  output chStrobeT [NCH-1:0]      strobe,
  output logic [1:0]              serCsN,
  output logic                    serClk,
  output logic                    serDio,
  output logic [1:0]              fastAtk,
  output logic [1:0]              stepClk,
  output logic [1:0]              stepDat,
  output logic [1:0]              stepSize
);
  logic isPar, isSer, isStep;

  always_comb begin
    isPar  = (modeE'(modeSel) == MODE_PAR);
    isSer  = (modeE'(modeSel) == MODE_SER);
    isStep = (modeE'(modeSel) == MODE_STEP0) || (modeE'(modeSel) == MODE_STEP1);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_strobe
    always_comb begin
      strobe[ch].loadPar  = pwrUp[ch] & isPar & ~hold[ch];
      strobe[ch].loadSer  = pwrUp[ch] & isSer & serWr[ch];
      strobe[ch].loadStep = pwrUp[ch] & isStep & stepWr[ch];
    end
  end

  always_comb begin
    serCsN   = isSer ? {pinsB[PIN_CS], pinsA[PIN_CS]} : 2'b11;
    serClk   = isSer & pinsB[PIN_SCLK];
    serDio   = isSer & pinsB[PIN_SDIO];
    fastAtk  = isSer ? {pinsB[PIN_FA], pinsA[PIN_FA]} : 2'b00;
    stepClk  = isStep ? {pinsB[PIN_STEPCLK], pinsA[PIN_STEPCLK]} : 2'b00;
    stepDat  = isStep ? {pinsB[PIN_STEPDAT], pinsA[PIN_STEPDAT]} : 2'b00;
    stepSize = isStep ? {pinsB[PIN_GSHI], pinsB[PIN_GSLO]} : 2'b00;
  end
endmodule

// File: rtl/gainsel_dp.sv
module gainsel_dp
  import gainsel_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CODE_W = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  chStrobeT [NCH-1:0]            strobe,
  input  logic [NCH-1:0][CODE_W-1:0]    parCode,
  input  logic [NCH-1:0][CODE_W-1:0]    serCode,
  input  logic [NCH-1:0][CODE_W-1:0]    stepCode,
  output logic [NCH-1:0][CODE_W-1:0]    gain
);
  localparam logic [CODE_W-1:0] MIN_GAIN = {CODE_W{1'b1}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CODE_W-1:0] codeQ;
    always_ff @(posedge clk) begin
      if (!rstN)                    codeQ <= MIN_GAIN;
      else if (strobe[ch].loadPar)  codeQ <= parCode[ch];
      else if (strobe[ch].loadSer)  codeQ <= serCode[ch];
      else if (strobe[ch].loadStep) codeQ <= stepCode[ch];
    end
    assign gain[ch] = codeQ;
  end
endmodule

// File: rtl/gainsel_top.sv
module gainsel_top
  import gainsel_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [CODE_W-1:0] pinsA,
  input  logic [CODE_W-1:0] pinsB,
  input  logic              holdA,
  input  logic              holdB,
  input  logic              pwrUpA,
  input  logic              pwrUpB,
  input  logic [CODE_W-1:0] serCodeA,
  input  logic              serWrA,
  input  logic [CODE_W-1:0] serCodeB,
  input  logic              serWrB,
  input  logic [CODE_W-1:0] stepCodeA,
  input  logic              stepWrA,
  input  logic [CODE_W-1:0] stepCodeB,
  input  logic              stepWrB,
  output logic [1:0]        serCsN,
  output logic              serClk,
  output logic              serDio,
  output logic [1:0]        fastAtk,
  output logic [1:0]        stepClk,
  output logic [1:0]        stepDat,
  output logic [1:0]        stepSize,
  output logic [CODE_W-1:0] gainA,
  output logic [CODE_W-1:0] gainB
);
  localparam int NCH = 2;

  chStrobeT [NCH-1:0]         strobe;
  logic [NCH-1:0][CODE_W-1:0] gainVec;

  gainsel_ctrl #(.NCH(NCH), .CODE_W(CODE_W)) u_ctrl (
    .modeSel (modeSel),
    .hold    ({holdB, holdA}),
    .pwrUp   ({pwrUpB, pwrUpA}),
    .serWr   ({serWrB, serWrA}),
    .stepWr  ({stepWrB, stepWrA}),
    .pinsA   (pinsA),
    .pinsB   (pinsB),
    .strobe  (strobe),
    .serCsN  (serCsN),
    .serClk  (serClk),
    .serDio  (serDio),
    .fastAtk (fastAtk),
    .stepClk (stepClk),
    .stepDat (stepDat),
    .stepSize(stepSize)
  );

  gainsel_dp #(.NCH(NCH), .CODE_W(CODE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .parCode ({pinsB, pinsA}),
    .serCode ({serCodeB, serCodeA}),
    .stepCode({stepCodeB, stepCodeA}),
    .gain    (gainVec)
  );

  assign gainA = gainVec[0];
  assign gainB = gainVec[1];
endmodule

// File: rtl/gainsel_checker.sv
module gainsel_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic [CODE_W-1:0] pinsA,
  input logic [CODE_W-1:0] pinsB,
  input logic              holdA,
  input logic              holdB,
  input logic              pwrUpA,
  input logic              pwrUpB,
  input logic [CODE_W-1:0] serCodeA,
  input logic              serWrA,
  input logic [CODE_W-1:0] stepCodeA,
  input logic              stepWrA,
  input logic [1:0]        serCsN,
  input logic              serClk,
  input logic              serDio,
  input logic [1:0]        fastAtk,
  input logic [1:0]        stepClk,
  input logic [1:0]        stepDat,
  input logic [1:0]        stepSize,
  input logic [CODE_W-1:0] gainA,
  input logic [CODE_W-1:0] gainB
);
  assert_reset_min_R1: assert property (@(posedge clk)
    !rstN |=> (gainA == {CODE_W{1'b1}}) && (gainB == {CODE_W{1'b1}}));

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && !holdA && pwrUpA) |=> gainA == $past(pinsA));

  assert_par_follow_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && !holdB && pwrUpB) |=> gainB == $past(pinsB));

  assert_hold_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b00 && holdA) |=> $stable(gainA));

  assert_hold_keep_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && modeSel == 2'b00 && holdB) |=> $stable(gainB));

  assert_ser_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && serWrA && pwrUpA) |=> gainA == $past(serCodeA));

  assert_step_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[1] && stepWrA && pwrUpA) |=> gainA == $past(stepCodeA));

  assert_pwrdn_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !pwrUpA) |=> $stable(gainA));

  assert_pwrdn_keep_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !pwrUpB) |=> $stable(gainB));

  assert_ser_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'b01) |-> (serCsN == 2'b11 && !serClk && !serDio && fastAtk == 2'b00));

  assert_ser_route_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01) |-> (serCsN[0] == pinsA[3] && serClk == pinsB[4] && serDio == pinsB[5]));

  assert_step_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1]) |-> (stepClk == 2'b00 && stepDat == 2'b00 && stepSize == 2'b00));

  assert_step_route_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[1]) |-> (stepClk[0] == pinsA[1] && stepDat[1] == pinsB[0] && stepSize == pinsB[3:2]));
endmodule

bind gainsel_top gainsel_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .pinsA(pinsA), .pinsB(pinsB),
  .holdA(holdA), .holdB(holdB), .pwrUpA(pwrUpA), .pwrUpB(pwrUpB),
  .serCodeA(serCodeA), .serWrA(serWrA), .stepCodeA(stepCodeA), .stepWrA(stepWrA),
  .serCsN(serCsN), .serClk(serClk), .serDio(serDio), .fastAtk(fastAtk),
  .stepClk(stepClk), .stepDat(stepDat), .stepSize(stepSize),
  .gainA(gainA), .gainB(gainB)
);

// File: tb/gainsel_top_test.sv
module gainsel_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [5:0] pinsA = '0, pinsB = '0;
  logic       holdA = 1'b0, holdB = 1'b0;
  logic       pwrUpA = 1'b1, pwrUpB = 1'b1;
  logic [5:0] serCodeA = '0, serCodeB = '0, stepCodeA = '0, stepCodeB = '0;
  logic       serWrA = 1'b0, serWrB = 1'b0, stepWrA = 1'b0, stepWrB = 1'b0;
  logic [1:0] serCsN, fastAtk, stepClk, stepDat, stepSize;
  logic       serClk, serDio;
  logic [5:0] gainA, gainB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [5:0] modelA = 6'd63, modelB = 6'd63;

  always #5 clk = ~clk;

  gainsel_top uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .pinsA(pinsA), .pinsB(pinsB),
    .holdA(holdA), .holdB(holdB), .pwrUpA(pwrUpA), .pwrUpB(pwrUpB),
    .serCodeA(serCodeA), .serWrA(serWrA), .serCodeB(serCodeB), .serWrB(serWrB),
    .stepCodeA(stepCodeA), .stepWrA(stepWrA), .stepCodeB(stepCodeB), .stepWrB(stepWrB),
    .serCsN(serCsN), .serClk(serClk), .serDio(serDio), .fastAtk(fastAtk),
    .stepClk(stepClk), .stepDat(stepDat), .stepSize(stepSize),
    .gainA(gainA), .gainB(gainB)
  );

  task automatic check(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  function automatic logic [5:0] nextCode(logic [5:0] cur, logic pwr, logic hold,
      logic [5:0] par, logic sw, logic [5:0] sc, logic tw, logic [5:0] tc);
    if (!pwr) return cur;
    case (modeSel)
      2'b00:   return hold ? cur : par;
      2'b01:   return sw ? sc : cur;
      default: return tw ? tc : cur;
    endcase
  endfunction

  // one clock: update reference model from stable inputs, then compare
  task automatic tick(string tag);
    @(posedge clk);
    if (!rstN) begin
      modelA = 6'd63;
      modelB = 6'd63;
    end else begin
      modelA = nextCode(modelA, pwrUpA, holdA, pinsA, serWrA, serCodeA, stepWrA, stepCodeA);
      modelB = nextCode(modelB, pwrUpB, holdB, pinsB, serWrB, serCodeB, stepWrB, stepCodeB);
    end
    #2;
    check(tag, "gainA", gainA, modelA);
    check(tag, "gainB", gainB, modelB);
  endtask

  task automatic checkRoute(string tag);
    bit ser, stp;
    #1;
    ser = (modeSel == 2'b01);
    stp = modeSel[1];
    check(tag, "serCsN", serCsN, ser ? {pinsB[3], pinsA[3]} : 2'b11);
    check(tag, "serClk", serClk, ser ? pinsB[4] : 1'b0);
    check(tag, "serDio", serDio, ser ? pinsB[5] : 1'b0);
    check(tag, "fastAtk", fastAtk, ser ? {pinsB[2], pinsA[2]} : 2'b00);
    check(tag, "stepClk", stepClk, stp ? {pinsB[1], pinsA[1]} : 2'b00);
    check(tag, "stepDat", stepDat, stp ? {pinsB[0], pinsA[0]} : 2'b00);
    check(tag, "stepSize", stepSize, stp ? {pinsB[3], pinsB[2]} : 2'b00);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2;
    // R1: reset state, pins changing under reset
    pinsA = 6'd5; pinsB = 6'd9;
    tick("R1"); tick("R1");
    rstN = 1'b1;
    pinsA = 6'd63; pinsB = 6'd63;
    tick("R1");

    // R2: transparent parallel, several patterns
    pinsA = 6'd0;  pinsB = 6'd42; tick("R2");
    pinsA = 6'd21; pinsB = 6'd1;  tick("R2");
    pinsA = 6'd63; pinsB = 6'd0;  tick("R2");
    pinsA = 6'd12; pinsB = 6'd33; tick("R2");
    checkRoute("R9");
    checkRoute("R10");

    // R3/R8: hold A, B stays transparent
    holdA = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pinsA = 6'(i * 11 + 3); pinsB = 6'(i * 7 + 2);
      tick("R3");
    end
    holdA = 1'b0; holdB = 1'b1;
    pinsA = 6'd44; pinsB = 6'd17; tick("R8");
    pinsA = 6'd45; pinsB = 6'd18; tick("R3");
    holdB = 1'b0; tick("R2");

    // R6: unselected strobes in parallel mode with hold high
    holdA = 1'b1; holdB = 1'b1;
    serCodeA = 6'd7; serWrA = 1'b1; stepCodeB = 6'd8; stepWrB = 1'b1;
    tick("R6");
    serWrA = 1'b0; stepWrB = 1'b0;

    // R6: mode change alone keeps codes
    modeSel = 2'b01; pinsA = 6'd1; pinsB = 6'd2; tick("R6");
    modeSel = 2'b10; tick("R6");
    modeSel = 2'b11; tick("R6");

    // R4: serial mode writes, parallel pins ignored
    modeSel = 2'b01; holdA = 1'b0; holdB = 1'b0;
    pinsA = 6'b101100; pinsB = 6'b011011;
    checkRoute("R9");
    pinsA = 6'b001000; pinsB = 6'b110100;
    checkRoute("R9");
    tick("R4");
    serCodeA = 6'd30; serWrA = 1'b1; tick("R4");
    serWrA = 1'b0; serCodeB = 6'd50; serWrB = 1'b1; tick("R8");
    serWrB = 1'b0; stepCodeA = 6'd3; stepWrA = 1'b1; tick("R6");
    stepWrA = 1'b0; serCodeA = 6'd0; serWrA = 1'b1; serCodeB = 6'd63; serWrB = 1'b1;
    tick("R4");
    serWrA = 1'b0; serWrB = 1'b0;

    // R5: up/down mode, both encodings
    modeSel = 2'b10;
    pinsA = 6'b000011; pinsB = 6'b001110;
    checkRoute("R10");
    pinsA = 6'b000001; pinsB = 6'b000101;
    checkRoute("R10");
    stepCodeA = 6'd40; stepWrA = 1'b1; tick("R5");
    stepWrA = 1'b0; serWrB = 1'b1; serCodeB = 6'd9; tick("R6");
    serWrB = 1'b0;
    modeSel = 2'b11;
    checkRoute("R10");
    stepCodeB = 6'd22; stepWrB = 1'b1; stepCodeA = 6'd41; stepWrA = 1'b1; tick("R5");
    stepWrA = 1'b0; stepWrB = 1'b0; tick("R5");

    // R7: power-down keeps code, then restores
    pwrUpA = 1'b0;
    stepCodeA = 6'd11; stepWrA = 1'b1; stepCodeB = 6'd12; stepWrB = 1'b1; tick("R7");
    stepWrB = 1'b0;
    modeSel = 2'b00; pinsA = 6'd59; pinsB = 6'd36; stepWrA = 1'b0;
    tick("R7"); tick("R7");
    check("R7", "gainA held", gainA, 6'd41);
    pwrUpB = 1'b0; holdA = 1'b1;
    pinsB = 6'd5; tick("R7");
    pwrUpA = 1'b1; pwrUpB = 1'b1; holdB = 1'b1; tick("R7");
    check("R7", "gainA after power-up", gainA, 6'd41);
    holdA = 1'b0; tick("R2");
    checkRoute("R9");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule